// File: doc/BRIEF.md
# PIPE Power State and Receiver Detect Controller

This block sits on the PHY side of a PIPE-style MAC interface and owns the link power state. The MAC drives a 2-bit power-down command, a request line that is shared between far-end receiver detection and loopback, a transmit-idle hint, and a synchronous reset. The controller keeps the current power state and acknowledges each accepted change on `phy_status`. While in the middle state it runs a timed receiver detection and reports the result on a 3-bit status bus. While in the full-power state it steers the transmitter onto looped-back receive symbols.

The same `phy_status` output has two shapes. A change among the three clocked states gives a one-cycle pulse. Reset, leaving the deepest state and detection results all hold it high as a level until the matching condition ends. A command that arrives while a handshake is still open is not acted on, and it raises `proto_err`. The analog detect circuit is outside the block: it is the `far_end_present` input, sampled when the detect window ends.

Top module: `pipe_pwr_ctrl`

## Requirements
- R1: While `rst` is high, `pwr_state` reads 2'b10, `phy_status` is 1, and `rx_status` and `loopback_sel` are 0. After release, `phy_status` stays high for exactly STABLE_CYC cycles and then falls.
- R2: A command differing from the current state, with both in {00, 01, 10}, is taken one cycle later. In that cycle `pwr_state` shows the new value and `phy_status` is high for exactly that one cycle.
- R3: A command of 2'b11 from any other state sets `pwr_state` to 2'b11 one cycle later, with no `phy_status` pulse.
- R4: Leaving 2'b11 updates `pwr_state` one cycle later. `phy_status` is then held high for STABLE_CYC cycles.
- R5: While a handshake is open (clock wait, one-cycle acknowledge, detection, or result hold/fall), a command that differs from `pwr_state` leaves the state unchanged. `proto_err` is then high in the following cycle. Once the handshake closes, the command is accepted.
- R6: With `pwr_state` = 2'b10, raising `det_lpbk_req` starts detection. DET_CYC cycles later, `rx_status` becomes 3'b011 if `far_end_present` is 1 (or 3'b000 if it is 0), and `phy_status` rises in the same cycle.
- R7: After detection, `phy_status` and `rx_status` hold while the request stays high. FALL_CYC cycles after the request drops, both return to 0.
- R8: In 2'b01 or 2'b11, the request has no effect: `phy_status`, `rx_status` and `loopback_sel` stay 0.
- R9: In 2'b00 with the request high, `loopback_sel` rises one cycle after the first cycle in which `sym_boundary` is 1, and not before.
- R10: When the request drops, `loopback_sel` is 0 one cycle later.
- R11: `tx_quiet` is 1 whenever `pwr_state` is not 2'b00. In 2'b00 it equals `tx_idle_in` while `loopback_sel` is 0, and it is 0 while `loopback_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_cmd | input | 2 | Requested power state: 00 full, 01 standby, 10 low, 11 off |
| det_lpbk_req | input | 1 | Detect request in state 10, loopback request in state 00 |
| tx_idle_in | input | 1 | MAC asks for electrical idle on the transmitter |
| far_end_present | input | 1 | Analog detect outcome, sampled at the end of the window |
| sym_boundary | input | 1 | Marks a transmit symbol boundary |
| pwr_state | output | 2 | Current power state |
| phy_status | output | 1 | Handshake acknowledge (pulse or level) |
| rx_status | output | 3 | Detection result code |
| proto_err | output | 1 | Command arrived while a handshake was open |
| loopback_sel | output | 1 | Transmitter sends looped-back receive symbols |
| tx_quiet | output | 1 | Transmitter held in electrical idle |

## Verification
Every result except `tx_quiet` is registered. The state change, the acknowledge pulse, `proto_err` and the loopback switch are therefore due one edge after the input that causes them. The held levels end exactly STABLE_CYC, DET_CYC or FALL_CYC edges after the accepting edge. The bench drives inputs on the falling edge and counts edges from that point. It samples on the last falling edge before each expected change and on the first one after it, so an off-by-one in any counter shows up. `tx_quiet` is combinational and is checked in the same half-cycle as its inputs.

// File: rtl/pipe_pwr_pkg.sv
`timescale 1ns/1ps
package pipe_pwr_pkg;

    typedef enum logic [1:0] {
        PS_P0  = 2'b00,
        PS_P0S = 2'b01,
        PS_P1  = 2'b10,
        PS_P2  = 2'b11
    } pstate_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAKE,
        PH_ACK,
        PH_DET,
        PH_HOLD,
        PH_FALL
    } phase_e;

    localparam logic [2:0] RXST_FOUND = 3'b011;
    localparam logic [2:0] RXST_NONE  = 3'b000;

    typedef struct packed {
        logic       ack;
        logic [2:0] rxst;
        logic       perr;
    } hs_t;

    function automatic logic [2:0] det_code(input logic present);
        return present ? RXST_FOUND : RXST_NONE;
    endfunction

    function automatic logic clocked_state(input pstate_e s);
        return s != PS_P2;
    endfunction

endpackage

// File: rtl/pps_cycle_timer.sv
`timescale 1ns/1ps
module pps_cycle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] lim,
    output logic          hit
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + 1'b1;
    end

    assign hit = (cnt_q == lim);
endmodule

// File: rtl/pps_loop_sel.sv
`timescale 1ns/1ps
module pps_loop_sel (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic in_p0,
    input  logic idle,
    input  logic boundary,
    output logic lb
);
    logic lb_q;

    always_ff @(posedge clk) begin
        if (rst)
            lb_q <= 1'b0;
        else
            lb_q <= req & in_p0 & (lb_q | (idle & boundary));
    end

    assign lb = lb_q;

    AST_LB_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(lb_q) |-> $past(boundary)); // R9

    AST_LB_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !req |=> !lb_q); // R10
endmodule

// File: rtl/pipe_pwr_ctrl.sv
`timescale 1ns/1ps
module pipe_pwr_ctrl
    import pipe_pwr_pkg::*;
#(
    parameter int STABLE_CYC = 16000,
    parameter int DET_CYC    = 300,
    parameter int FALL_CYC   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pd_cmd,
    input  logic       det_lpbk_req,
    input  logic       tx_idle_in,
    input  logic       far_end_present,
    input  logic       sym_boundary,
    output logic [1:0] pwr_state,
    output logic       phy_status,
    output logic [2:0] rx_status,
    output logic       proto_err,
    output logic       loopback_sel,
    output logic       tx_quiet
);
    localparam int MAX_DF = (DET_CYC > FALL_CYC) ? DET_CYC : FALL_CYC;
    localparam int MAXC   = (STABLE_CYC > MAX_DF) ? STABLE_CYC : MAX_DF;
    localparam int CW     = $clog2(MAXC + 1);

    pstate_e       st_q, st_d, cmd;
    phase_e        ph_q, ph_d;
    hs_t           hs_q, hs_d;
    logic          tm_clr, tm_en, tm_hit, busy;
    logic [CW-1:0] tm_lim;

    assign cmd  = pstate_e'(pd_cmd);
    assign busy = (ph_q != PH_IDLE);

    // Shared window counter: phases that need timing never overlap.
    always_comb begin
        case (ph_q)
            PH_WAKE: tm_lim = CW'(STABLE_CYC - 1);
            PH_DET:  tm_lim = CW'(DET_CYC - 1);
            default: tm_lim = CW'(FALL_CYC - 1);
        endcase
    end

    pps_cycle_timer #(.CW(CW)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (tm_clr),
        .en  (tm_en),
        .lim (tm_lim),
        .hit (tm_hit)
    );

    always_comb begin
        st_d    = st_q;
        ph_d    = ph_q;
        hs_d    = hs_q;
        hs_d.perr = busy && (cmd != st_q);
        tm_clr  = 1'b0;
        tm_en   = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (cmd != st_q) begin
                    st_d   = cmd;
                    tm_clr = 1'b1;
                    if (cmd == PS_P2) begin
                        ph_d = PH_IDLE;
                    end else if (!clocked_state(st_q)) begin
                        ph_d     = PH_WAKE;
                        hs_d.ack = 1'b1;
                    end else begin
                        ph_d     = PH_ACK;
                        hs_d.ack = 1'b1;
                    end
                end else if (det_lpbk_req && st_q == PS_P1) begin
                    ph_d   = PH_DET;
                    tm_clr = 1'b1;
                end
            end
            PH_WAKE: begin
                if (tm_hit) begin
                    ph_d     = PH_IDLE;
                    hs_d.ack = 1'b0;
                    tm_clr   = 1'b1;
                end else begin
                    tm_en = 1'b1;
                end
            end
            PH_ACK: begin
                ph_d     = PH_IDLE;
                hs_d.ack = 1'b0;
            end
            PH_DET: begin
                if (tm_hit) begin
                    ph_d      = PH_HOLD;
                    hs_d.ack  = 1'b1;
                    hs_d.rxst = det_code(far_end_present);
                    tm_clr    = 1'b1;
                end else begin
                    tm_en = 1'b1;
                end
            end
            PH_HOLD: begin
                if (!det_lpbk_req) begin
                    ph_d   = PH_FALL;
                    tm_clr = 1'b1;
                end
            end
            PH_FALL: begin
                if (tm_hit) begin
                    ph_d      = PH_IDLE;
                    hs_d.ack  = 1'b0;
                    hs_d.rxst = RXST_NONE;
                    tm_clr    = 1'b1;
                end else begin
                    tm_en = 1'b1;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PS_P1;
            ph_q <= PH_WAKE;
            hs_q <= '{ack: 1'b1, rxst: RXST_NONE, perr: 1'b0};
        end else begin
            st_q <= st_d;
            ph_q <= ph_d;
            hs_q <= hs_d;
        end
    end

    pps_loop_sel u_loop (
        .clk      (clk),
        .rst      (rst),
        .req      (det_lpbk_req),
        .in_p0    (st_q == PS_P0),
        .idle     (ph_q == PH_IDLE),
        .boundary (sym_boundary),
        .lb       (loopback_sel)
    );

    assign pwr_state  = st_q;
    assign phy_status = hs_q.ack;
    assign rx_status  = hs_q.rxst;
    assign proto_err  = hs_q.perr;
    assign tx_quiet   = (st_q != PS_P0) | (tx_idle_in & ~loopback_sel);

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_ACK) |=> !phy_status); // R2

    AST_P2_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE && st_q != PS_P2 && cmd == PS_P2)
            |=> (!phy_status && pwr_state == 2'b11)); // R3

    AST_STATE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> (st_q == $past(st_q))); // R5

    AST_DET_RESULT: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_HOLD) |-> (phy_status &&
            (rx_status == RXST_FOUND || rx_status == RXST_NONE))); // R6

    AST_IGNORE_REQ: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE && (st_q == PS_P0S || st_q == PS_P2) && cmd == st_q)
            |=> (!phy_status && rx_status == RXST_NONE)); // R8
endmodule

// File: tb/sim_pipe_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_pipe_pwr_ctrl;
    localparam int STB  = 40;
    localparam int DET  = 12;
    localparam int FALL = 3;

    logic       clk = 1'b0;
    logic       rst, req, tx_idle, far, sb;
    logic [1:0] pd;
    logic [1:0] pwr_state;
    logic       phy_status, proto_err, loopback_sel, tx_quiet;
    logic [2:0] rx_status;

    int checks = 0;
    int fails  = 0;
    int cur    = 2;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pipe_pwr_ctrl #(.STABLE_CYC(STB), .DET_CYC(DET), .FALL_CYC(FALL)) u0 (
        .clk(clk), .rst(rst), .pd_cmd(pd), .det_lpbk_req(req),
        .tx_idle_in(tx_idle), .far_end_present(far), .sym_boundary(sb),
        .pwr_state(pwr_state), .phy_status(phy_status), .rx_status(rx_status),
        .proto_err(proto_err), .loopback_sel(loopback_sel), .tx_quiet(tx_quiet)
    );

    function automatic int exp_quiet(input int st, input bit idle, input bit lb);
        return (st != 0) ? 1 : ((idle && !lb) ? 1 : 0);
    endfunction

    function automatic int exp_det(input bit present);
        return present ? 3 : 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_state(input int t);
        if (t == cur) begin
            tick(1);
            chk("R2 no change", int'(pwr_state), cur);
            chk("R2 no ack", int'(phy_status), 0);
        end else if (t == 3) begin
            pd = 2'(t); tick(1);
            chk("R3 state", int'(pwr_state), 3);
            chk("R3 no ack", int'(phy_status), 0);
            cur = 3;
        end else if (cur == 3) begin
            pd = 2'(t); tick(1);
            chk("R4 state", int'(pwr_state), t);
            chk("R4 ack rise", int'(phy_status), 1);
            tick(STB - 1);
            chk("R4 ack held", int'(phy_status), 1);
            tick(1);
            chk("R4 ack fall", int'(phy_status), 0);
            cur = t;
        end else begin
            pd = 2'(t); tick(1);
            chk("R2 state", int'(pwr_state), t);
            chk("R2 pulse", int'(phy_status), 1);
            tick(1);
            chk("R2 pulse end", int'(phy_status), 0);
            cur = t;
        end
    endtask

    task automatic run_detect(input bit present);
        far = present; req = 1'b1;
        tick(1);
        tick(DET - 1);
        chk("R6 not yet", int'(phy_status), 0);
        tick(1);
        chk("R6 ack", int'(phy_status), 1);
        chk("R6 code", int'(rx_status), exp_det(present));
        far = ~present;
        tick(4);
        chk("R7 hold ack", int'(phy_status), 1);
        chk("R7 hold code", int'(rx_status), exp_det(present));
        req = 1'b0;
        tick(1);
        tick(FALL - 1);
        chk("R7 before fall", int'(phy_status), 1);
        tick(1);
        chk("R7 fall ack", int'(phy_status), 0);
        chk("R7 fall code", int'(rx_status), 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        rst = 1'b1; pd = 2'd2; req = 1'b0; tx_idle = 1'b1; far = 1'b0; sb = 1'b0;
        tick(3);
        chk("R1 reset state", int'(pwr_state), 2);
        chk("R1 reset ack", int'(phy_status), 1);
        chk("R1 reset lb", int'(loopback_sel), 0);
        chk("R1 reset code", int'(rx_status), 0);
        rst = 1'b0;
        tick(3);
        pd = 2'd0; tick(1);
        chk("R5 early cmd flagged", int'(proto_err), 1);
        chk("R5 early cmd ignored", int'(pwr_state), 2);
        pd = 2'd2; tick(1);
        chk("R5 flag clears", int'(proto_err), 0);
        tick(STB - 1 - 5);
        chk("R1 still waiting", int'(phy_status), 1);
        tick(1);
        chk("R1 clocks stable", int'(phy_status), 0);

        run_detect(1'b1);
        run_detect(1'b0);

        // command during the one-cycle acknowledge
        pd = 2'd0; tick(1);
        chk("R2 state", int'(pwr_state), 0);
        pd = 2'd1; tick(1);
        chk("R5 ack busy ignored", int'(pwr_state), 0);
        chk("R5 ack busy flagged", int'(proto_err), 1);
        tick(1);
        chk("R5 taken later", int'(pwr_state), 1);
        chk("R5 taken ack", int'(phy_status), 1);
        tick(1);
        cur = 1;

        req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            chk("R8 standby ack", int'(phy_status), 0);
            chk("R8 standby lb", int'(loopback_sel), 0);
            chk("R8 standby code", int'(rx_status), 0);
        end
        req = 1'b0;

        go_state(0);
        tx_idle = 1'b1; sb = 1'b0; req = 1'b1;
        tick(4);
        chk("R9 waits for boundary", int'(loopback_sel), 0);
        chk("R11 idle no loop", int'(tx_quiet), exp_quiet(0, 1'b1, 1'b0));
        sb = 1'b1; tick(1);
        chk("R9 switched", int'(loopback_sel), 1);
        sb = 1'b0;
        #1;
        chk("R11 loop overrides idle", int'(tx_quiet), exp_quiet(0, 1'b1, 1'b1));
        tick(1);
        chk("R9 stays", int'(loopback_sel), 1);
        req = 1'b0; tick(1);
        chk("R10 release", int'(loopback_sel), 0);
        chk("R11 idle again", int'(tx_quiet), exp_quiet(0, 1'b1, 1'b0));

        go_state(3);
        req = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick(1);
            chk("R8 off ack", int'(phy_status), 0);
            chk("R8 off lb", int'(loopback_sel), 0);
        end
        req = 1'b0;
        go_state(2);

        for (int i = 0; i < 30; i++) begin
            int t;
            t = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
            tx_idle = 1'($urandom % 2);
            go_state(t);
            #1;
            chk("R11 random", int'(tx_quiet), exp_quiet(cur, tx_idle, 1'b0));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule